// File: doc/BRIEF.md
# I2C Channel-Select Slave Controller

This block is the digital core of a two-way downstream bus switch that is configured over I2C. It listens to the upstream SCL and SDA lines, which are oversampled by a fast system clock, and recognises its own 7-bit address. A write transfer then loads a byte that chooses which of the two downstream channels are connected. A read transfer returns a status byte that shows the committed channel selection together with the live state of two active-low interrupt lines, one for each channel.

A channel selection does not take effect when its byte is acknowledged. It is held in a staging register and is copied to the channel-enable outputs only when the bus later shows STOP. The downstream lines are therefore never connected in the middle of a transfer. If one transfer carries several data bytes, the last one wins. A repeated START drops whatever is staged. A synchronised active-low bus-reset input clears the block without waiting for a power cycle. The asynchronous reset `rst_ni` stands in for power-on reset.

The pass gates, voltage translation and supply sensing are outside this block. SDA is driven through an open-drain pull-low output.

Top module: `i2c_chsel_ctrl`

## Requirements
- R1: After `rst_ni` both channel enables are 0 and `sda_pull_o` is 0.
- R2: The device address is `11100` followed by `addr_strap_i[1]` and `addr_strap_i[0]`, and bit 0 of the address byte selects read (1) or write (0). The slave acknowledges a matching address and every byte it receives by pulling SDA low for the whole high phase of the ninth clock. A non-matching address is not acknowledged, and SDA stays released until the next START or STOP.
- R3: Data bit 0 enables channel 0 and data bit 1 enables channel 1. Both may be set at once.
- R4: `chan_en_o` keeps its old value after the data byte is acknowledged. It takes the new value only after the following STOP.
- R5: When several data bytes arrive in one write transfer, only the last byte decides the committed selection.
- R6: A read returns `{2'b00, int1, int0, 2'b00, chan_en[1:0]}`, sent MSB first. Here intN is 1 when `irq_ni[N]` is low, and the byte is captured at the falling edge of the address-acknowledge clock.
- R7: Writes to data bits 7 to 2 change neither the channel enables nor the value read back.
- R8: Holding `bus_rst_ni` low clears the channel enables and the staged value, returns the bus engine to idle and releases SDA.
- R9: A repeated START before STOP throws away an uncommitted written byte. A STOP that follows a transfer without a completed write leaves the channel enables unchanged.
- R10: In a read, a master acknowledge makes the slave send the status byte again. A master no-acknowledge makes the slave release SDA for the rest of the transfer.
- R11: A low pulse of one sample clock on SDA while SCL is high is filtered out. It is seen neither as START nor as STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| bus_rst_ni | input | 1 | Active-low bus recovery reset, synchronised internally |
| scl_i | input | 1 | Upstream SCL line level |
| sda_i | input | 1 | Upstream SDA line level (wired, includes own pull) |
| addr_strap_i | input | 2 | Low two bits of the device address |
| irq_ni | input | 2 | Active-low interrupt lines, bit N for channel N |
| sda_pull_o | output | 1 | Open-drain drive: 1 pulls SDA low |
| chan_en_o | output | 2 | Committed channel enables, bit N for channel N |

## Verification
The checker assumes a single well-behaved master: SDA moves only while SCL is low, except at START and STOP. It also assumes that each level lasts far longer than the filter and synchroniser delay, so that the slave's own pull never changes during a filtered SCL high phase. The bench drives the bus in quarter-bit steps of 20 sample clocks and changes SDA one quarter after SCL falls. It puts a glitch into the high phase on purpose only in the single-sample filter test, and that glitch is a short enough that the filter must remove it. Interrupt lines and the straps are changed only while the bus is idle, well before the next address byte.

// File: rtl/i2c_chsel_pkg.sv
package i2c_chsel_pkg;
  localparam int NUM_CH = 2;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/i2c_chsel_filt.sv
// Per-bit synchroniser followed by 3-tap majority vote.
module i2c_chsel_filt #(
  parameter int              W       = 2,
  parameter int              SYNC    = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int TAPS = 3;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [SYNC-1:0] sy;
    logic [TAPS-1:0] hist;
    logic            vote;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sy   <= {SYNC{RST_VAL[g]}};
        hist <= {TAPS{RST_VAL[g]}};
        vote <= RST_VAL[g];
      end else begin
        sy   <= {sy[SYNC-2:0], d_i[g]};
        hist <= {hist[TAPS-2:0], sy[SYNC-1]};
        vote <= (hist[0] & hist[1]) | (hist[1] & hist[2]) | (hist[0] & hist[2]);
      end
    end

    assign q_o[g] = vote;
  end
endmodule

// File: rtl/i2c_chsel_cond.sv
// Edge and START/STOP detection on filtered lines.
module i2c_chsel_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (clr_i) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_q;
  assign scl_fall_o = ~scl_f_i & scl_q;
  assign start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;
endmodule

// File: rtl/i2c_chsel_fsm.sv
module i2c_chsel_fsm
  import i2c_chsel_pkg::*;
#(
  parameter int CTRL_W = NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              pull_o,
  output logic [CTRL_W-1:0] wr_bits_o,
  output logic              wr_stb_o,
  output logic              commit_o,
  output bus_st_e           state_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              rnw;
  logic              mack;
  logic              wr_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rnw       <= 1'b0;
      mack      <= 1'b0;
      wr_done   <= 1'b0;
      pull_o    <= 1'b0;
      wr_bits_o <= '0;
      wr_stb_o  <= 1'b0;
      commit_o  <= 1'b0;
    end else if (clr_i) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rnw       <= 1'b0;
      mack      <= 1'b0;
      wr_done   <= 1'b0;
      pull_o    <= 1'b0;
      wr_bits_o <= '0;
      wr_stb_o  <= 1'b0;
      commit_o  <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      commit_o <= 1'b0;
      if (start_i) begin
        // repeated START drops an unfinished write
        st      <= ST_ADDR;
        cnt     <= '0;
        pull_o  <= 1'b0;
        wr_done <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        pull_o   <= 1'b0;
        commit_o <= wr_done;
        wr_done  <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == FULL) begin
              if (sh[BYTE_W-1:1] == dev_addr_i) begin
                rnw    <= sh[0];
                pull_o <= 1'b1;
                st     <= ST_AACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt <= '0;
              if (rnw) begin
                tx     <= rd_byte_i;
                pull_o <= ~rd_byte_i[BYTE_W-1];
                st     <= ST_RDATA;
              end else begin
                pull_o <= 1'b0;
                st     <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise_i) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == FULL) begin
              wr_bits_o <= sh[CTRL_W-1:0];
              wr_stb_o  <= 1'b1;
              wr_done   <= 1'b1;
              pull_o    <= 1'b1;
              st        <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall_i) begin
              pull_o <= 1'b0;
              cnt    <= '0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt == FULL) begin
                pull_o <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                pull_o <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack) begin
                tx     <= rd_byte_i;
                pull_o <= ~rd_byte_i[BYTE_W-1];
                cnt    <= '0;
                st     <= ST_RDATA;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = st;
endmodule

// File: rtl/i2c_chsel_ctrl.sv
module i2c_chsel_ctrl
  import i2c_chsel_pkg::*;
#(
  parameter logic [4:0] ADDR_FIXED = 5'b11100,
  parameter int         SYNC       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_strap_i,
  input  logic [NUM_CH-1:0] irq_ni,
  output logic              sda_pull_o,
  output logic [NUM_CH-1:0] chan_en_o
);
  localparam int PAD_W = (BYTE_W - 2 * NUM_CH) / 2;

  logic [SYNC-1:0]   brst_q;
  logic              bus_clr;
  logic              scl_f, sda_f;
  logic [NUM_CH-1:0] irq_f;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] dev_addr;
  logic [BYTE_W-1:0] rd_byte;
  logic [NUM_CH-1:0] wr_bits, staged;
  logic              wr_stb, commit;
  bus_st_e           st_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brst_q <= '1;
    else         brst_q <= {brst_q[SYNC-2:0], bus_rst_ni};
  end
  assign bus_clr = ~brst_q[SYNC-1];

  i2c_chsel_filt #(.W(2), .SYNC(SYNC), .RST_VAL(2'b11)) u_bus_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_f, sda_f})
  );

  i2c_chsel_filt #(.W(NUM_CH), .SYNC(SYNC), .RST_VAL('1)) u_irq_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_ni),
    .q_o   (irq_f)
  );

  i2c_chsel_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (bus_clr),
    .scl_f_i   (scl_f),
    .sda_f_i   (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  assign dev_addr = {ADDR_FIXED, addr_strap_i};
  assign rd_byte  = {{PAD_W{1'b0}}, ~irq_f, {PAD_W{1'b0}}, chan_en_o};

  i2c_chsel_fsm #(.CTRL_W(NUM_CH)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (bus_clr),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .sda_i     (sda_f),
    .dev_addr_i(dev_addr),
    .rd_byte_i (rd_byte),
    .pull_o    (sda_pull_o),
    .wr_bits_o (wr_bits),
    .wr_stb_o  (wr_stb),
    .commit_o  (commit),
    .state_o   (st_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged    <= '0;
      chan_en_o <= '0;
    end else if (bus_clr) begin
      staged    <= '0;
      chan_en_o <= '0;
    end else begin
      if (wr_stb) staged    <= wr_bits;
      if (commit) chan_en_o <= staged;
    end
  end
endmodule

// File: rtl/i2c_chsel_chk.sv
module i2c_chsel_chk
  import i2c_chsel_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_clr_i,
  input logic              stop_i,
  input logic              scl_f_i,
  input bus_st_e           state_i,
  input logic [NUM_CH-1:0] chan_en_i,
  input logic              sda_pull_i
);
  // R4: enables move only two cycles after STOP, or after a bus reset
  a_r4_commit_at_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_en_i) |-> ($past(stop_i, 2) || $past(bus_clr_i)));

  // R8: bus reset clears enables and releases SDA
  a_r8_bus_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_clr_i |=> (chan_en_i == '0 && !sda_pull_i));

  // R2: pull level never moves while filtered SCL stays high
  a_r2_ack_held_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f_i && $past(scl_f_i) && !bus_clr_i && !$past(bus_clr_i)) |-> $stable(sda_pull_i));

  // R2: unaddressed, SDA is released
  a_r2_skip_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SKIP) |-> !sda_pull_i);

  // R10: idle bus never pulled
  a_r10_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_pull_i);
endmodule

bind i2c_chsel_ctrl i2c_chsel_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_clr_i (bus_clr),
  .stop_i    (stop_det),
  .scl_f_i   (scl_f),
  .state_i   (st_w),
  .chan_en_i (chan_en_o),
  .sda_pull_i(sda_pull_o)
);

// File: tb/i2c_chsel_ctrl_tb.sv
module i2c_chsel_ctrl_tb;
  localparam int Q = 20;

  typedef struct packed {
    int         req;
    logic [7:0] val;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst_n = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b01;
  logic [1:0] irq_n = 2'b11;
  logic       sda_pull;
  logic [1:0] chan_en;
  logic       sda_bus;

  sb_item_t   exp_q[$];
  logic [7:0] act_q[$];
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_chsel_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_rst_ni  (bus_rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .addr_strap_i(strap),
    .irq_ni      (irq_n),
    .sda_pull_o  (sda_pull),
    .chan_en_o   (chan_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver pushes expected, observed value goes to the actual queue
  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    exp_q.push_back('{req: req, val: exp});
    act_q.push_back(act);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        sb_item_t   e;
        logic [7:0] a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_chk++;
        if (a !== e.val) begin
          n_fail++;
          $display("FAIL R%0d: got %02h expected %02h", e.req, a, e.val);
        end
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    sda_m = b; tick(Q);
    scl_m = 1'b1;
    if (glitch && b) begin
      tick(Q);
      sda_m = 1'b0; tick(1);
      sda_m = 1'b1; tick(Q - 1);
    end else begin
      tick(2 * Q);
    end
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, input bit glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch);
    get_bit(s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~mack, 1'b0);
  endtask

  // single-byte write with stop, checks acks and result
  task automatic wr1(input int req, input logic [6:0] a, input logic [7:0] d,
                     input bit glitch, input logic [1:0] exp_en);
    logic ack;
    bus_start();
    put_byte({a, 1'b0}, 1'b0, ack);
    check(req, {7'd0, ack}, 8'h01);
    put_byte(d, glitch, ack);
    check(req, {7'd0, ack}, 8'h01);
    bus_stop();
    check(req, {6'd0, chan_en}, {6'd0, exp_en});
  endtask

  task automatic rd1(input int req, input logic [6:0] a, input logic [7:0] exp);
    logic       ack;
    logic [7:0] d;
    bus_start();
    put_byte({a, 1'b1}, 1'b0, ack);
    check(req, {7'd0, ack}, 8'h01);
    get_byte(1'b0, d);
    check(req, d, exp);
    bus_stop();
  endtask

  initial begin
    logic       ack;
    logic [7:0] d;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1: reset state
    check(1, {6'd0, chan_en}, 8'h00);
    check(1, {7'd0, sda_pull}, 8'h00);

    // R3 / R4: channel 0, no change before STOP
    bus_start();
    put_byte({7'h71, 1'b0}, 1'b0, ack);
    check(2, {7'd0, ack}, 8'h01);             // R2 address ack
    put_byte(8'h01, 1'b0, ack);
    check(2, {7'd0, ack}, 8'h01);             // R2 data ack
    check(4, {6'd0, chan_en}, 8'h00);         // R4 not yet applied
    bus_stop();
    check(3, {6'd0, chan_en}, 8'h01);         // R3 channel 0

    wr1(3, 7'h71, 8'h02, 1'b0, 2'b10);        // R3 channel 1
    wr1(3, 7'h71, 8'h03, 1'b0, 2'b11);        // R3 both

    // R5: multi-byte, last wins
    bus_start();
    put_byte({7'h71, 1'b0}, 1'b0, ack);
    put_byte(8'h01, 1'b0, ack);
    put_byte(8'h02, 1'b0, ack);
    put_byte(8'h00, 1'b0, ack);
    check(5, {7'd0, ack}, 8'h01);
    bus_stop();
    check(5, {6'd0, chan_en}, 8'h00);
    bus_start();
    put_byte({7'h71, 1'b0}, 1'b0, ack);
    put_byte(8'h02, 1'b0, ack);
    put_byte(8'h01, 1'b0, ack);
    bus_stop();
    check(5, {6'd0, chan_en}, 8'h01);

    // R6: read format with interrupt patterns
    rd1(6, 7'h71, 8'h01);
    irq_n = 2'b10; tick(Q);
    rd1(6, 7'h71, 8'h11);
    irq_n = 2'b01; tick(Q);
    rd1(6, 7'h71, 8'h21);
    irq_n = 2'b00; tick(Q);
    rd1(6, 7'h71, 8'h31);
    irq_n = 2'b11; tick(Q);

    // R7: upper bits ignored
    wr1(7, 7'h71, 8'hF2, 1'b0, 2'b10);
    rd1(7, 7'h71, 8'h02);
    wr1(7, 7'h71, 8'hFC, 1'b0, 2'b00);
    rd1(7, 7'h71, 8'h00);
    wr1(7, 7'h71, 8'h02, 1'b0, 2'b10);

    // R10: master ack repeats, nack releases
    bus_start();
    put_byte({7'h71, 1'b1}, 1'b0, ack);
    get_byte(1'b1, d);
    check(10, d, 8'h02);
    get_byte(1'b0, d);
    check(10, d, 8'h02);
    check(10, {7'd0, sda_pull}, 8'h00);
    get_bit(ack);
    check(10, {7'd0, ack}, 8'h01);            // line stays high after nack
    bus_stop();

    // R2: wrong address not acked, no effect
    bus_start();
    put_byte({7'h72, 1'b0}, 1'b0, ack);
    check(2, {7'd0, ack}, 8'h00);
    put_byte(8'h01, 1'b0, ack);
    check(2, {7'd0, ack}, 8'h00);
    bus_stop();
    check(2, {6'd0, chan_en}, 8'h02);

    // R2: strap change moves the address
    strap = 2'b10; tick(Q);
    wr1(2, 7'h72, 8'h01, 1'b0, 2'b01);

    // R9: repeated start aborts the staged byte
    bus_start();
    put_byte({7'h72, 1'b0}, 1'b0, ack);
    put_byte(8'h02, 1'b0, ack);
    check(9, {7'd0, ack}, 8'h01);
    bus_start();
    put_byte({7'h72, 1'b1}, 1'b0, ack);
    get_byte(1'b0, d);
    check(9, d, 8'h01);
    bus_stop();
    check(9, {6'd0, chan_en}, 8'h01);

    // R11: single-sample glitches in high phases
    wr1(11, 7'h72, 8'h03, 1'b1, 2'b11);

    // R8: bus reset
    bus_rst_n = 1'b0; tick(4);
    bus_rst_n = 1'b1; tick(6);
    check(8, {6'd0, chan_en}, 8'h00);
    check(8, {7'd0, sda_pull}, 8'h00);
    rd1(8, 7'h72, 8'h00);

    tick(10);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule